// File: doc/BRIEF.md
# X-Bus Peripheral Select and Transceiver Control

This block sits between an ISA-style system bus and a buffered 8-bit peripheral bus. It decodes the ISA address (SA plus the latched upper address LA[23:17]) and the four ISA commands into active-low chip selects for a boot ROM, a keyboard controller, an embedded microcontroller, a real-time clock and a configurable number of programmable I/O windows. It also drives the direction and output-enable pins of the data transceiver that joins the peripheral bus to the system data bus, and it produces the clock-chip address-latch pulse.

Chip selects and the transceiver controls follow the commands combinationally, so they switch in the same cycle as a command edge. Two pieces of state exist: a hold flag that keeps the transceiver enabled after an ISA-master command ends until the address leaves the device, and a counter that stretches the address-latch pulse to two clocks. Five pins can each be handed over to a plain general-purpose output value. Device enables, window bases and masks are plain inputs.

Top module: `xbus_select`

## Requirements
- R1: `kbc_cs_n` is low while an I/O command (`ior_n` or `iow_n` low) is active, `dev_en[0]` is 1 and SA[15:0] is 0x0060 or 0x0064; at most one of the ROM, keyboard, microcontroller and clock selects is low at a time.
- R2: `mc_cs_n` is low while an I/O command is active, `dev_en[1]` is 1 and SA[15:0] is 0x0062 or 0x0066.
- R3: `rtc_cs_n` is low while an I/O command is active, `dev_en[2]` is 1 and SA[15:0] is 0x0071; port 0x0070 never drives it.
- R4: A falling edge of `iow_n` seen at a rising clock while SA[15:0] is 0x0070 and `dev_en[2]` is 1 makes `rtc_ale` high for exactly the two following clock cycles; other ports or a cleared enable give no pulse.
- R5: With the 24-bit address A = {LA[23:17], SA[16:0]} and A[23:20] equal to 0x0 or 0xF, `bios_cs_n` is low while `memr_n` or `memw_n` is low and either A[19:16] is 0xF with `bios_en[0]` set or A[19:16] is 0xE with `bios_en[1]` set.
- R6: `pcs_cs_n[i]` is low only while an I/O command from a PCI master (`pci_master` = 1) is active, `pcs_en[i]` is 1 and (SA[15:0] & ~mask_i) equals (base_i & ~mask_i), where window i occupies bits [16i+15:16i] of `pcs_base` and `pcs_mask`.
- R7: `xdir_n` is low while `ior_n` is low at any address, and while `memr_n` is low with the ROM decoded; a write or an undecoded memory read leaves it high.
- R8: While `dma_cyc` is 1 and `dma_xbus_rd` is 1, `xdir_n` is low exactly while `dack_n` is low.
- R9: `xoe_n` is low while a command is active and an enabled device is decoded (ROM, keyboard, microcontroller, clock ports 0x70/0x71, programmable windows); a disabled device leaves it high.
- R10: For a PCI master `xoe_n` returns high in the cycle the command ends; for an ISA master it stays low after the command ends until the address no longer decodes to an enabled device.
- R11: `gpo_mode[k]` set replaces pin k by `gpo_val[k]`, with k = 0 `kbc_cs_n`, 1 `rtc_ale`, 2 `rtc_cs_n`, 3 `xdir_n`, 4 `xoe_n`.
- R12: While `rst` is high every active-low output is high and `rtc_ale` is low, whatever the inputs.
- R13: While `dma_cyc` is 1 no chip select is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst | input | 1 | Synchronous active-high reset |
| sa | input | 20 | ISA system address |
| la_hi | input | 7 | Latched upper address LA[23:17] |
| ior_n | input | 1 | I/O read command, active low |
| iow_n | input | 1 | I/O write command, active low |
| memr_n | input | 1 | Memory read command, active low |
| memw_n | input | 1 | Memory write command, active low |
| dack_n | input | 1 | DMA acknowledge, active low |
| dma_cyc | input | 1 | A DMA cycle is in progress |
| dma_xbus_rd | input | 1 | The DMA transfer reads from a peripheral-bus device |
| pci_master | input | 1 | 1 for a PCI-initiated cycle, 0 for an ISA master |
| bios_en | input | 2 | ROM window enables (0: xF segment, 1: xE segment) |
| dev_en | input | 3 | Enables: 0 keyboard, 1 microcontroller, 2 clock |
| pcs_en | input | NPCS | Programmable window enables |
| pcs_base | input | 16*NPCS | Window base addresses |
| pcs_mask | input | 16*NPCS | Window don't-care masks |
| gpo_mode | input | 5 | Per-pin general-purpose output select |
| gpo_val | input | 5 | Per-pin general-purpose output value |
| bios_cs_n | output | 1 | ROM select |
| kbc_cs_n | output | 1 | Keyboard controller select |
| mc_cs_n | output | 1 | Microcontroller select |
| rtc_cs_n | output | 1 | Clock data-port select |
| rtc_ale | output | 1 | Clock address-latch pulse, active high |
| pcs_cs_n | output | NPCS | Programmable window selects |
| xdir_n | output | 1 | Transceiver direction, low toward the system bus |
| xoe_n | output | 1 | Transceiver output enable |

## Verification
The two functions that overlap in one cycle are the address-latch pulse and the clock data-port select: an index write to port 0x70 is followed at the very next falling clock by a read of port 0x71, so the second cycle of the pulse coincides with the read. The check then expects `rtc_ale` high, `rtc_cs_n` low, `xdir_n` low and `xoe_n` low together, and a cycle later the pulse must end while the select stays low.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int ADDR_W   = 24;
    localparam int PORT_W   = 16;
    localparam int GPO_W    = 5;

    localparam int GPO_KBC  = 0;
    localparam int GPO_ALE  = 1;
    localparam int GPO_RTC  = 2;
    localparam int GPO_XDIR = 3;
    localparam int GPO_XOE  = 4;

    localparam logic [PORT_W-1:0] PORT_KBC_DAT = 16'h0060;
    localparam logic [PORT_W-1:0] PORT_KBC_CMD = 16'h0064;
    localparam logic [PORT_W-1:0] PORT_MC_DAT  = 16'h0062;
    localparam logic [PORT_W-1:0] PORT_MC_CMD  = 16'h0066;
    localparam logic [PORT_W-1:0] PORT_RTC_IDX = 16'h0070;
    localparam logic [PORT_W-1:0] PORT_RTC_DAT = 16'h0071;

    // Internal select bundle, active high.
    typedef struct packed {
        logic rom;
        logic kbc;
        logic mcu;
        logic clk_dat;
    } dev_sel_t;

    // ROM windows: low-megabyte copy and top-of-space alias.
    function automatic logic rom_window(input logic [ADDR_W-1:0] a,
                                        input logic [1:0]        en);
        logic top_ok;
        top_ok = (a[23:20] == 4'h0) || (a[23:20] == 4'hF);
        return top_ok && ((en[0] && a[19:16] == 4'hF) ||
                          (en[1] && a[19:16] == 4'hE));
    endfunction

    function automatic logic window_hit(input logic [PORT_W-1:0] port,
                                        input logic [PORT_W-1:0] base,
                                        input logic [PORT_W-1:0] mask);
        return (port & ~mask) == (base & ~mask);
    endfunction

endpackage

// File: rtl/xbus_addr_dec.sv
module xbus_addr_dec
    import xbus_pkg::*;
#(
    parameter int NPCS = 2
) (
    input  logic [19:0]          sa,
    input  logic [6:0]           la_hi,
    input  logic                 io_cmd,
    input  logic                 mem_cmd,
    input  logic                 dma_cyc,
    input  logic                 pci_master,
    input  logic [1:0]           bios_en,
    input  logic [2:0]           dev_en,
    input  logic [NPCS-1:0]      pcs_en,
    input  logic [16*NPCS-1:0]   pcs_base,
    input  logic [16*NPCS-1:0]   pcs_mask,
    output dev_sel_t             sel,
    output logic [NPCS-1:0]      pcs_sel,
    output logic                 clk_idx_addr,
    output logic                 addr_any,
    output logic                 cmd_hit
);
    logic [ADDR_W-1:0] full_addr;
    logic [PORT_W-1:0] port;
    logic              live;
    logic              rom_addr, kbc_addr, mcu_addr, clk_dat_addr;
    logic [NPCS-1:0]   pcs_addr;

    assign full_addr = {la_hi, sa[16:0]};
    assign port      = sa[PORT_W-1:0];
    assign live      = ~dma_cyc;

    assign rom_addr     = live & rom_window(full_addr, bios_en);
    assign kbc_addr     = live & dev_en[0] &
                          ((port == PORT_KBC_DAT) || (port == PORT_KBC_CMD));
    assign mcu_addr     = live & dev_en[1] &
                          ((port == PORT_MC_DAT) || (port == PORT_MC_CMD));
    assign clk_dat_addr = live & dev_en[2] & (port == PORT_RTC_DAT);
    assign clk_idx_addr = live & dev_en[2] & (port == PORT_RTC_IDX);

    for (genvar i = 0; i < NPCS; i++) begin : g_win
        assign pcs_addr[i] = live & pci_master & pcs_en[i] &
                             window_hit(port, pcs_base[16*i +: 16], pcs_mask[16*i +: 16]);
        assign pcs_sel[i]  = pcs_addr[i] & io_cmd;
    end

    always_comb begin
        sel.rom     = rom_addr & mem_cmd;
        sel.kbc     = kbc_addr & io_cmd;
        sel.mcu     = mcu_addr & io_cmd;
        sel.clk_dat = clk_dat_addr & io_cmd;
    end

    assign addr_any = rom_addr | kbc_addr | mcu_addr | clk_dat_addr |
                      clk_idx_addr | (|pcs_addr);
    assign cmd_hit  = (|sel) | (|pcs_sel) | (clk_idx_addr & io_cmd);

endmodule

// File: rtl/xbus_ale_gen.sv
module xbus_ale_gen #(
    parameter int PULSE = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic iow_n,
    input  logic idx_addr,
    output logic ale
);
    localparam int CNT_W = $clog2(PULSE + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE);

    logic             iow_prev;
    logic [CNT_W-1:0] remain;
    logic             start;

    assign start = iow_prev & ~iow_n & idx_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            iow_prev <= 1'b1;
            remain   <= '0;
        end else begin
            iow_prev <= iow_n;
            if (start)
                remain <= LOAD;
            else if (remain != '0)
                remain <= remain - 1'b1;
        end
    end

    assign ale = (remain != '0);

endmodule

// File: rtl/xbus_xcvr_ctl.sv
module xbus_xcvr_ctl (
    input  logic clk,
    input  logic rst,
    input  logic ior_n,
    input  logic memr_n,
    input  logic rom_sel,
    input  logic dma_cyc,
    input  logic dack_n,
    input  logic dma_xbus_rd,
    input  logic pci_master,
    input  logic cmd_hit,
    input  logic addr_any,
    output logic xdir_n,
    output logic xoe_n
);
    logic isa_hold;

    // ISA masters keep the buffer enabled until the address moves away.
    always_ff @(posedge clk) begin
        if (rst)
            isa_hold <= 1'b0;
        else
            isa_hold <= ~pci_master & addr_any & (cmd_hit | isa_hold);
    end

    assign xoe_n  = ~(cmd_hit | (~pci_master & isa_hold & addr_any));

    assign xdir_n = ~((~ior_n) |
                      (~memr_n & rom_sel) |
                      (dma_cyc & dma_xbus_rd & ~dack_n));

endmodule

// File: rtl/xbus_select.sv
module xbus_select
    import xbus_pkg::*;
#(
    parameter int NPCS      = 2,
    parameter int ALE_WIDTH = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [19:0]          sa,
    input  logic [6:0]           la_hi,
    input  logic                 ior_n,
    input  logic                 iow_n,
    input  logic                 memr_n,
    input  logic                 memw_n,
    input  logic                 dack_n,
    input  logic                 dma_cyc,
    input  logic                 dma_xbus_rd,
    input  logic                 pci_master,
    input  logic [1:0]           bios_en,
    input  logic [2:0]           dev_en,
    input  logic [NPCS-1:0]      pcs_en,
    input  logic [16*NPCS-1:0]   pcs_base,
    input  logic [16*NPCS-1:0]   pcs_mask,
    input  logic [4:0]           gpo_mode,
    input  logic [4:0]           gpo_val,
    output logic                 bios_cs_n,
    output logic                 kbc_cs_n,
    output logic                 mc_cs_n,
    output logic                 rtc_cs_n,
    output logic                 rtc_ale,
    output logic [NPCS-1:0]      pcs_cs_n,
    output logic                 xdir_n,
    output logic                 xoe_n
);
    logic            io_cmd, mem_cmd;
    dev_sel_t        sel;
    logic [NPCS-1:0] pcs_sel;
    logic            clk_idx_addr, addr_any, cmd_hit;
    logic            ale_fn, xdir_fn, xoe_fn;
    logic [GPO_W-1:0] shared_fn, shared_pin, shared_idle;

    assign io_cmd  = ~ior_n | ~iow_n;
    assign mem_cmd = ~memr_n | ~memw_n;

    xbus_addr_dec #(.NPCS(NPCS)) u_dec (
        .sa           (sa),
        .la_hi        (la_hi),
        .io_cmd       (io_cmd),
        .mem_cmd      (mem_cmd),
        .dma_cyc      (dma_cyc),
        .pci_master   (pci_master),
        .bios_en      (bios_en),
        .dev_en       (dev_en),
        .pcs_en       (pcs_en),
        .pcs_base     (pcs_base),
        .pcs_mask     (pcs_mask),
        .sel          (sel),
        .pcs_sel      (pcs_sel),
        .clk_idx_addr (clk_idx_addr),
        .addr_any     (addr_any),
        .cmd_hit      (cmd_hit)
    );

    xbus_ale_gen #(.PULSE(ALE_WIDTH)) u_ale (
        .clk      (clk),
        .rst      (rst),
        .iow_n    (iow_n),
        .idx_addr (clk_idx_addr),
        .ale      (ale_fn)
    );

    xbus_xcvr_ctl u_xcvr (
        .clk         (clk),
        .rst         (rst),
        .ior_n       (ior_n),
        .memr_n      (memr_n),
        .rom_sel     (sel.rom),
        .dma_cyc     (dma_cyc),
        .dack_n      (dack_n),
        .dma_xbus_rd (dma_xbus_rd),
        .pci_master  (pci_master),
        .cmd_hit     (cmd_hit),
        .addr_any    (addr_any),
        .xdir_n      (xdir_fn),
        .xoe_n       (xoe_fn)
    );

    // Shared pins: functional value, idle value, optional general-purpose override.
    always_comb begin
        shared_fn             = '0;
        shared_fn[GPO_KBC]    = ~sel.kbc;
        shared_fn[GPO_ALE]    = ale_fn;
        shared_fn[GPO_RTC]    = ~sel.clk_dat;
        shared_fn[GPO_XDIR]   = xdir_fn;
        shared_fn[GPO_XOE]    = xoe_fn;
        shared_idle           = '1;
        shared_idle[GPO_ALE]  = 1'b0;
    end

    for (genvar k = 0; k < GPO_W; k++) begin : g_pin
        assign shared_pin[k] = rst         ? shared_idle[k] :
                               gpo_mode[k] ? gpo_val[k]     : shared_fn[k];
    end

    assign kbc_cs_n  = shared_pin[GPO_KBC];
    assign rtc_ale   = shared_pin[GPO_ALE];
    assign rtc_cs_n  = shared_pin[GPO_RTC];
    assign xdir_n    = shared_pin[GPO_XDIR];
    assign xoe_n     = shared_pin[GPO_XOE];
    assign bios_cs_n = rst | ~sel.rom;
    assign mc_cs_n   = rst | ~sel.mcu;
    assign pcs_cs_n  = {NPCS{rst}} | ~pcs_sel;

endmodule

// File: rtl/xbus_select_chk.sv
module xbus_select_chk #(
    parameter int NPCS = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            ior_n,
    input logic            iow_n,
    input logic            memr_n,
    input logic            memw_n,
    input logic            dma_cyc,
    input logic            pci_master,
    input logic [4:0]      gpo_mode,
    input logic            bios_cs_n,
    input logic            kbc_cs_n,
    input logic            mc_cs_n,
    input logic            rtc_cs_n,
    input logic            rtc_ale,
    input logic [NPCS-1:0] pcs_cs_n,
    input logic            xdir_n,
    input logic            xoe_n
);
    // R12
    a_r12_reset_idle: assert property (@(posedge clk)
        rst |-> (bios_cs_n && kbc_cs_n && mc_cs_n && rtc_cs_n && !rtc_ale &&
                 (&pcs_cs_n) && xdir_n && xoe_n));

    // R13
    a_r13_dma_no_select: assert property (@(posedge clk) disable iff (rst)
        dma_cyc |-> (bios_cs_n && mc_cs_n && (&pcs_cs_n) &&
                     (kbc_cs_n || gpo_mode[0]) && (rtc_cs_n || gpo_mode[2])));

    // R6
    a_r6_window_pci_only: assert property (@(posedge clk) disable iff (rst)
        !pci_master |-> (&pcs_cs_n));

    // R7
    a_r7_xdir_io_read: assert property (@(posedge clk) disable iff (rst)
        (!ior_n && !gpo_mode[3]) |-> !xdir_n);

    // R4
    a_r4_ale_two_cycles: assert property (@(posedge clk) disable iff (rst)
        (!gpo_mode[1] && $rose(rtc_ale)) |=> (rtc_ale || gpo_mode[1]));

    // R10
    a_r10_pci_release: assert property (@(posedge clk) disable iff (rst)
        (pci_master && ior_n && iow_n && memr_n && memw_n && !gpo_mode[4]) |-> xoe_n);

    // R1
    a_r1_single_select: assert property (@(posedge clk) disable iff (rst)
        (gpo_mode == 5'b0) |->
            ($countones({~bios_cs_n, ~kbc_cs_n, ~mc_cs_n, ~rtc_cs_n}) <= 1));

endmodule

bind xbus_select xbus_select_chk #(.NPCS(NPCS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ior_n      (ior_n),
    .iow_n      (iow_n),
    .memr_n     (memr_n),
    .memw_n     (memw_n),
    .dma_cyc    (dma_cyc),
    .pci_master (pci_master),
    .gpo_mode   (gpo_mode),
    .bios_cs_n  (bios_cs_n),
    .kbc_cs_n   (kbc_cs_n),
    .mc_cs_n    (mc_cs_n),
    .rtc_cs_n   (rtc_cs_n),
    .rtc_ale    (rtc_ale),
    .pcs_cs_n   (pcs_cs_n),
    .xdir_n     (xdir_n),
    .xoe_n      (xoe_n)
);

// File: tb/sim_xbus_select.sv
`timescale 1ns/1ps
module sim_xbus_select;

    localparam int NPCS = 2;
    localparam int NVEC = 19;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [19:0]       sa = '0;
    logic [6:0]        la_hi = '0;
    logic              ior_n = 1'b1, iow_n = 1'b1, memr_n = 1'b1, memw_n = 1'b1;
    logic              dack_n = 1'b1, dma_cyc = 1'b0, dma_xbus_rd = 1'b0;
    logic              pci_master = 1'b1;
    logic [1:0]        bios_en = 2'b11;
    logic [2:0]        dev_en = 3'b111;
    logic [NPCS-1:0]   pcs_en = 2'b11;
    logic [16*NPCS-1:0] pcs_base = {16'h0480, 16'h0300};
    logic [16*NPCS-1:0] pcs_mask = {16'h0001, 16'h000F};
    logic [4:0]        gpo_mode = '0, gpo_val = '0;
    logic              bios_cs_n, kbc_cs_n, mc_cs_n, rtc_cs_n, rtc_ale, xdir_n, xoe_n;
    logic [NPCS-1:0]   pcs_cs_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    xbus_select #(.NPCS(NPCS)) u0 (
        .clk(clk), .rst(rst), .sa(sa), .la_hi(la_hi),
        .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n), .memw_n(memw_n),
        .dack_n(dack_n), .dma_cyc(dma_cyc), .dma_xbus_rd(dma_xbus_rd),
        .pci_master(pci_master), .bios_en(bios_en), .dev_en(dev_en),
        .pcs_en(pcs_en), .pcs_base(pcs_base), .pcs_mask(pcs_mask),
        .gpo_mode(gpo_mode), .gpo_val(gpo_val),
        .bios_cs_n(bios_cs_n), .kbc_cs_n(kbc_cs_n), .mc_cs_n(mc_cs_n),
        .rtc_cs_n(rtc_cs_n), .rtc_ale(rtc_ale), .pcs_cs_n(pcs_cs_n),
        .xdir_n(xdir_n), .xoe_n(xoe_n)
    );

    // {addr24, cmd{ior,iow,memr,memw}, dma, pci, expected{rom,kbc,mc,rtc,pcs1,pcs0,xdir,xoe}}
    localparam logic [37:0] VEC [NVEC] = '{
        {24'h000060, 4'b1000, 1'b0, 1'b1, 8'hBC},  // R1 read
        {24'h000064, 4'b0100, 1'b0, 1'b1, 8'hBE},  // R1 write
        {24'h000062, 4'b1000, 1'b0, 1'b1, 8'hDC},  // R2
        {24'h000066, 4'b0100, 1'b0, 1'b1, 8'hDE},  // R2
        {24'h000071, 4'b1000, 1'b0, 1'b1, 8'hEC},  // R3
        {24'h000071, 4'b0100, 1'b0, 1'b1, 8'hEE},  // R3
        {24'h000061, 4'b1000, 1'b0, 1'b1, 8'hFD},  // R7 read of no device
        {24'h0FFFF0, 4'b0010, 1'b0, 1'b1, 8'h7C},  // R5 read
        {24'h0F8000, 4'b0001, 1'b0, 1'b1, 8'h7E},  // R5 write
        {24'h0E4000, 4'b0010, 1'b0, 1'b1, 8'h7C},  // R5 E segment
        {24'hFE1234, 4'b0010, 1'b0, 1'b1, 8'h7C},  // R5 alias
        {24'h0D0000, 4'b0010, 1'b0, 1'b1, 8'hFF},  // R7 undecoded memory read
        {24'h1F0000, 4'b0010, 1'b0, 1'b1, 8'hFF},  // R5 bad top nibble
        {24'h000305, 4'b1000, 1'b0, 1'b1, 8'hF8},  // R6 window 0
        {24'h000481, 4'b0100, 1'b0, 1'b1, 8'hF6},  // R6 window 1
        {24'h000310, 4'b1000, 1'b0, 1'b1, 8'hFD},  // R6 miss
        {24'h000060, 4'b1000, 1'b1, 1'b1, 8'hFD},  // R13 io in DMA
        {24'h0FFFF0, 4'b0010, 1'b1, 1'b1, 8'hFF},  // R13 rom in DMA
        {24'h000305, 4'b1000, 1'b0, 1'b0, 8'hFD}   // R6 ISA master
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic [23:0] addr, input logic [3:0] cmd,
                         input logic dma, input logic pci);
        sa         = addr[19:0];
        la_hi      = addr[23:17];
        ior_n      = ~cmd[3];
        iow_n      = ~cmd[2];
        memr_n     = ~cmd[1];
        memw_n     = ~cmd[0];
        dma_cyc    = dma;
        pci_master = pci;
    endtask

    function automatic logic [7:0] outs();
        return {bios_cs_n, kbc_cs_n, mc_cs_n, rtc_cs_n, pcs_cs_n[1], pcs_cs_n[0], xdir_n, xoe_n};
    endfunction

    initial begin
        // R12: reset holds outputs idle despite an active access
        @(negedge clk);
        drive(24'h000070, 4'b1100, 1'b0, 1'b1);
        #5;
        check("R12 reset idle", {23'b0, rtc_ale, outs()}, {23'b0, 1'b0, 8'hFF});
        @(negedge clk);
        @(negedge clk);
        check("R12 reset idle later", {23'b0, rtc_ale, outs()}, {23'b0, 1'b0, 8'hFF});
        drive(24'h0, 4'b0000, 1'b0, 1'b1);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][37:14], VEC[i][13:10], VEC[i][9], VEC[i][8]);
            #5;
            check($sformatf("R1-table vector %0d (R2 R3 R5 R6 R7 R13)", i), {24'b0, outs()}, {24'b0, VEC[i][7:0]});
            @(negedge clk);
            drive(24'h0, 4'b0000, 1'b0, 1'b1);
            @(negedge clk);
        end

        // R9: disabled decode leaves the transceiver off
        dev_en = 3'b000;
        drive(24'h000060, 4'b1000, 1'b0, 1'b1);
        #5;
        check("R9 disabled kbc", {30'b0, kbc_cs_n, xoe_n}, {30'b0, 2'b11});
        check("R7 io read with disabled device", {31'b0, xdir_n}, 32'd0);
        @(negedge clk);
        bios_en = 2'b00;
        drive(24'h0F0000, 4'b0010, 1'b0, 1'b1);
        #5;
        check("R9 disabled rom", {29'b0, bios_cs_n, xdir_n, xoe_n}, {29'b0, 3'b111});
        @(negedge clk);
        dev_en = 3'b111;
        bios_en = 2'b11;
        drive(24'h0, 4'b0000, 1'b0, 1'b1);
        @(negedge clk);

        // R10: ISA master keeps the enable until the address moves
        drive(24'h000060, 4'b1000, 1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        drive(24'h000060, 4'b0000, 1'b0, 1'b0);
        #5;
        check("R10 isa hold after command", {30'b0, kbc_cs_n, xoe_n}, {30'b0, 2'b10});
        @(negedge clk);
        check("R10 isa hold second cycle", {31'b0, xoe_n}, 32'd0);
        drive(24'h000200, 4'b0000, 1'b0, 1'b0);
        #5;
        check("R10 isa release on address", {31'b0, xoe_n}, 32'd1);
        @(negedge clk);
        drive(24'h000060, 4'b0000, 1'b0, 1'b0);
        #5;
        check("R10 no re-enable without command", {31'b0, xoe_n}, 32'd1);
        @(negedge clk);
        // PCI master releases with the command
        drive(24'h000060, 4'b1000, 1'b0, 1'b1);
        @(negedge clk);
        @(negedge clk);
        drive(24'h000060, 4'b0000, 1'b0, 1'b1);
        #5;
        check("R10 pci release on command", {31'b0, xoe_n}, 32'd1);
        @(negedge clk);

        // R4: latch pulse of two cycles
        drive(24'h000070, 4'b0100, 1'b0, 1'b1);
        #5;
        check("R4 no pulse before edge sampled", {31'b0, rtc_ale}, 32'd0);
        check("R3 index port leaves data select off", {30'b0, rtc_cs_n, xoe_n}, {30'b0, 2'b10});
        #10;
        check("R4 pulse cycle 1", {31'b0, rtc_ale}, 32'd1);
        #20;
        check("R4 pulse cycle 2", {31'b0, rtc_ale}, 32'd1);
        #20;
        check("R4 pulse ended", {31'b0, rtc_ale}, 32'd0);
        #20;
        check("R4 held command no retrigger", {31'b0, rtc_ale}, 32'd0);
        @(negedge clk);
        drive(24'h0, 4'b0000, 1'b0, 1'b1);
        @(negedge clk);
        drive(24'h000072, 4'b0100, 1'b0, 1'b1);
        #15;
        check("R4 other port no pulse", {31'b0, rtc_ale}, 32'd0);
        @(negedge clk);
        drive(24'h0, 4'b0000, 1'b0, 1'b1);
        dev_en = 3'b011;
        @(negedge clk);
        drive(24'h000070, 4'b0100, 1'b0, 1'b1);
        #15;
        check("R4 disabled clock no pulse", {31'b0, rtc_ale}, 32'd0);
        @(negedge clk);
        drive(24'h0, 4'b0000, 1'b0, 1'b1);
        dev_en = 3'b111;
        @(negedge clk);

        // Overlap: pulse still high while the data-port read begins
        drive(24'h000070, 4'b0100, 1'b0, 1'b1);
        @(negedge clk);
        drive(24'h000071, 4'b1000, 1'b0, 1'b1);
        #15;
        check("R4 pulse during data read", {31'b0, rtc_ale}, 32'd1);
        check("R3 data select during pulse", {29'b0, rtc_cs_n, xdir_n, xoe_n}, {29'b0, 3'b000});
        #20;
        check("R4 pulse ends under data read", {30'b0, rtc_ale, rtc_cs_n}, {30'b0, 2'b00});
        @(negedge clk);
        drive(24'h0, 4'b0000, 1'b0, 1'b1);
        @(negedge clk);

        // R8: DMA direction follows acknowledge
        drive(24'h0, 4'b0000, 1'b1, 1'b1);
        dma_xbus_rd = 1'b1;
        #5;
        check("R8 dack high", {31'b0, xdir_n}, 32'd1);
        @(negedge clk);
        dack_n = 1'b0;
        #5;
        check("R8 dack low", {31'b0, xdir_n}, 32'd0);
        @(negedge clk);
        dma_xbus_rd = 1'b0;
        #5;
        check("R8 transfer toward device", {31'b0, xdir_n}, 32'd1);
        @(negedge clk);
        dack_n = 1'b1;
        drive(24'h0, 4'b0000, 1'b0, 1'b1);
        @(negedge clk);

        // R11: shared pins as general-purpose outputs
        gpo_mode = 5'b11111;
        gpo_val  = 5'b10101;
        drive(24'h000060, 4'b1000, 1'b0, 1'b1);
        #5;
        check("R11 gpo pattern A", {27'b0, xoe_n, xdir_n, rtc_cs_n, rtc_ale, kbc_cs_n},
              {27'b0, 5'b10101});
        @(negedge clk);
        gpo_val = 5'b01010;
        drive(24'h0, 4'b0000, 1'b0, 1'b1);
        #5;
        check("R11 gpo pattern B", {27'b0, xoe_n, xdir_n, rtc_cs_n, rtc_ale, kbc_cs_n},
              {27'b0, 5'b01010});
        @(negedge clk);
        gpo_mode = 5'b00001;
        gpo_val  = 5'b00001;
        drive(24'h000060, 4'b1000, 1'b0, 1'b1);
        #5;
        check("R11 single pin override", {29'b0, kbc_cs_n, xdir_n, xoe_n}, {29'b0, 3'b100});
        @(negedge clk);
        gpo_mode = '0;
        gpo_val  = '0;
        drive(24'h0, 4'b0000, 1'b0, 1'b1);
        @(negedge clk);

        // R12: reset in mid-access clears outputs and the pulse
        drive(24'h000070, 4'b0100, 1'b0, 1'b1);
        #15;
        rst = 1'b1;
        #1;
        check("R12 reset mid pulse", {23'b0, rtc_ale, outs()}, {23'b0, 1'b0, 8'hFF});
        @(negedge clk);
        drive(24'h0, 4'b0000, 1'b0, 1'b1);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12 idle after reset", {23'b0, rtc_ale, outs()}, {23'b0, 1'b0, 8'hFF});

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule